// File: doc/BRIEF.md
# Paired Receive Buffer Manager

This block sits between a frame receiver and a host and manages two receive frame buffers that are used as a pair. The receiver writes each incoming frame, byte by byte, into the buffer selected by a receiver-side pointer. The host reads frame bytes, the frame length and a set of four status flags from the buffer selected by a host-side pointer. Each buffer carries its own status flags, so the host always sees the flags that belong to the frame it is reading. When the host has finished with a buffer, it releases that buffer with a toggle command. The toggle marks the buffer empty and moves the host pointer to the other buffer.

The receiver pointer moves on to the other buffer whenever its own buffer is full and the other one is empty. This happens either when a frame completes or as soon as the host releases a buffer. If a frame starts while the receiver's buffer is still full, the block latches an overrun. It then stops the receiver and refuses further reception until the host issues the receiver-off command, which discards both buffers and realigns the pointers. An interrupt is raised from the unmasked flags of the host-selected buffer. A flag can be cleared only while its mask bit is set, so that clearing it can never produce an interrupt glitch.

Top module: `rx_pair_buf_mgr`

## Requirements
- R1: After a synchronous reset, both pointers select buffer 0, both buffers are empty with all status flags 0, overrun and rxActive are 0, and the mask is all ones, so irq is 0.
- R2: Frame bytes are stored in the receiver buffer in order from address 0. Frame done records the byte count as the frame length and sets the flags of that buffer. The flag bit positions are: bit 0 is frame good (set when rxCrcErr is 0), bit 1 is frame error (set when rxCrcErr is 1), and bit 2 is data ready. hostStatus, frameLen and rdData show the buffer that hostPtr selects.
- R3: rxPtr switches to the other buffer on the same edge where its own buffer becomes full, or where the other buffer is released, provided the other buffer is then empty. Otherwise rxPtr holds.
- R4: When no overrun is pending, cmdToggle flips hostPtr, marks the released buffer empty and clears all of its flags, all on one edge.
- R5: cmdRxEnable sets rxActive only when hostPtr equals rxPtr and no overrun is pending. Otherwise it is ignored.
- R6: When autoReEnable is 0, a completed frame clears rxActive. When autoReEnable is 1, rxActive stays 1.
- R7: A byte or frame-done that arrives while rxActive is 1 and the receiver buffer is full sets overrun and clears rxActive. While overrun is pending, received data, cmdRxEnable and cmdToggle have no effect.
- R8: cmdRxOff clears rxActive. When overrun is pending, cmdRxOff also clears overrun, empties both buffers, clears all flags and frame lengths, and returns both pointers to buffer 0.
- R9: irq is the OR, over the four flags of the host buffer, of each flag ANDed with the inverse of its mask bit. A mask bit of 1 masks its flag. maskWr loads maskData into the mask.
- R10: A status clear with bit vector statusClr clears a host-buffer flag only where both statusClr and the mask bit are 1. Flags that are unmasked are left unchanged.
- R11: An rxDetect pulse during active reception sets flag bit 3 (detection done) of the receiver buffer.
- R12: Bytes beyond DEPTH in one frame are dropped, and the frame length saturates at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdRxEnable | input | 1 | Receiver enable command strobe |
| cmdRxOff | input | 1 | Receiver off / error recovery strobe |
| cmdToggle | input | 1 | Host buffer release and pointer flip |
| statusClr | input | 4 | Flag clear strobes for the host buffer |
| maskWr | input | 1 | Mask load strobe |
| maskData | input | 4 | New interrupt mask (1 = masked) |
| autoReEnable | input | 1 | Keep listening after each frame |
| rdAddr | input | $clog2(DEPTH) | Host read byte address |
| rdData | output | DATA_W | Byte of the host buffer at rdAddr |
| frameLen | output | $clog2(DEPTH+1) | Stored length of the host buffer |
| hostStatus | output | 4 | Flags of the host buffer |
| hostPtr | output | 1 | Host-side buffer pointer |
| rxPtr | output | 1 | Receiver-side buffer pointer |
| rxActive | output | 1 | Receiver listening |
| overrun | output | 1 | Overrun pending |
| irq | output | 1 | Interrupt request |
| rxByteValid | input | 1 | Received byte strobe |
| rxByte | input | DATA_W | Received byte |
| rxFrameDone | input | 1 | End of frame strobe |
| rxCrcErr | input | 1 | Frame check failed, valid with rxFrameDone |
| rxDetect | input | 1 | Detection done strobe |

## Verification
The bench builds the block with DATA_W of 8 and DEPTH of 4. With a four-byte buffer, a six-byte frame runs past the end of its buffer, which exercises the length saturation and the dropping of late bytes. Short frames also fill both buffers within a few cycles, so the ordered hand-over between the two pointers, the overrun entry and the recovery through receiver-off can all be reached in one short directed sequence.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int FLAG_GOOD  = 0;
  localparam int FLAG_ERR   = 1;
  localparam int FLAG_READY = 2;
  localparam int FLAG_DET   = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic wr;        // store one byte
    logic frameEnd;  // latch length, restart index
    logic abort;     // restart index, keep lengths
    logic wipe;      // zero both stored lengths
    logic bufSel;    // receiver buffer being written
  } rpb_strobe_t;
endpackage

// File: rtl/rpb_ctrl.sv
module rpb_ctrl
  import rpb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdRxEnable,
  input  logic                 cmdRxOff,
  input  logic                 cmdToggle,
  input  logic [NUM_FLAGS-1:0] statusClr,
  input  logic                 maskWr,
  input  logic [NUM_FLAGS-1:0] maskData,
  input  logic                 autoReEnable,
  input  logic                 rxByteValid,
  input  logic                 rxFrameDone,
  input  logic                 rxCrcErr,
  input  logic                 rxDetect,
  output rpb_strobe_t          strobe,
  output logic                 hostPtr,
  output logic                 rxPtr,
  output logic                 rxActive,
  output logic                 overrun,
  output logic [NUM_FLAGS-1:0] hostStatus,
  output logic                 irq,
  output logic [NUM_FLAGS-1:0] maskState
);
  logic                           rxPtrQ, rxPtrD, hostPtrQ, hostPtrD;
  logic                           activeQ, activeD, ovrQ, ovrD;
  logic [1:0]                     fullQ, fullD;
  logic [1:0][NUM_FLAGS-1:0]      flagQ, flagD;
  logic [NUM_FLAGS-1:0]           maskQ, maskD, clrSel;
  logic accept, blocked, ovrHit, wrOk, doneOk, detOk, toggleOk, recover;

  always_comb begin
    accept   = activeQ && !ovrQ && !cmdRxOff;
    blocked  = fullQ[rxPtrQ];
    ovrHit   = accept && blocked && (rxByteValid || rxFrameDone);
    wrOk     = accept && !blocked && rxByteValid;
    doneOk   = accept && !blocked && rxFrameDone;
    detOk    = accept && !blocked && rxDetect;
    toggleOk = cmdToggle && !ovrQ;
    recover  = cmdRxOff && ovrQ;
    clrSel   = statusClr & maskQ;
  end

  // Buffer occupancy and per-buffer flags
  always_comb begin
    fullD = fullQ;
    flagD = flagQ;
    flagD[hostPtrQ] = flagQ[hostPtrQ] & ~clrSel;
    if (toggleOk) begin
      fullD[hostPtrQ] = 1'b0;
      flagD[hostPtrQ] = '0;
    end
    if (detOk) flagD[rxPtrQ][FLAG_DET] = 1'b1;
    if (doneOk) begin
      fullD[rxPtrQ]             = 1'b1;
      flagD[rxPtrQ][FLAG_READY] = 1'b1;
      flagD[rxPtrQ][FLAG_GOOD]  = !rxCrcErr;
      flagD[rxPtrQ][FLAG_ERR]   = rxCrcErr;
    end
    if (recover) begin
      fullD = '0;
      flagD = '0;
    end
  end

  // Pointers, receiver state, overrun, mask
  always_comb begin
    rxPtrD = rxPtrQ;
    if (recover)
      rxPtrD = 1'b0;
    else if (fullD[rxPtrQ] && !fullD[~rxPtrQ])
      rxPtrD = ~rxPtrQ;

    hostPtrD = hostPtrQ;
    if (recover)       hostPtrD = 1'b0;
    else if (toggleOk) hostPtrD = ~hostPtrQ;

    activeD = activeQ;
    if (doneOk && !autoReEnable) activeD = 1'b0;
    if (ovrHit)                  activeD = 1'b0;
    if (cmdRxOff)                activeD = 1'b0;
    if (cmdRxEnable && !ovrQ && !cmdRxOff && (hostPtrQ == rxPtrQ))
      activeD = 1'b1;

    ovrD = ovrQ;
    if (ovrHit)  ovrD = 1'b1;
    if (recover) ovrD = 1'b0;

    maskD = maskWr ? maskData : maskQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxPtrQ   <= 1'b0;
      hostPtrQ <= 1'b0;
      activeQ  <= 1'b0;
      ovrQ     <= 1'b0;
      fullQ    <= '0;
      flagQ    <= '0;
      maskQ    <= '1;
    end else begin
      rxPtrQ   <= rxPtrD;
      hostPtrQ <= hostPtrD;
      activeQ  <= activeD;
      ovrQ     <= ovrD;
      fullQ    <= fullD;
      flagQ    <= flagD;
      maskQ    <= maskD;
    end
  end

  always_comb begin
    strobe.wr       = wrOk;
    strobe.frameEnd = doneOk;
    strobe.abort    = cmdRxOff || ovrHit;
    strobe.wipe     = recover;
    strobe.bufSel   = rxPtrQ;
  end

  assign hostPtr    = hostPtrQ;
  assign rxPtr      = rxPtrQ;
  assign rxActive   = activeQ;
  assign overrun    = ovrQ;
  assign hostStatus = flagQ[hostPtrQ];
  assign irq        = |(flagQ[hostPtrQ] & ~maskQ);
  assign maskState  = maskQ;
endmodule

// File: rtl/rpb_datapath.sv
module rpb_datapath
  import rpb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  rpb_strobe_t                strobe,
  input  logic [DATA_W-1:0]          wrByte,
  input  logic                       hostPtr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output logic [$clog2(DEPTH+1)-1:0] frameLen
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH+1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);

  logic [LEN_W-1:0] wrIdxQ, nextIdx;
  logic             room, store;
  logic [DATA_W-1:0] rdBank [2];
  logic [LEN_W-1:0]  lenBank [2];

  assign room    = wrIdxQ < LEN_MAX;
  assign store   = strobe.wr && room;
  assign nextIdx = wrIdxQ + LEN_W'(store);

  always_ff @(posedge clk) begin
    if (rst)                  wrIdxQ <= '0;
    else if (strobe.frameEnd) wrIdxQ <= '0;
    else if (strobe.abort)    wrIdxQ <= '0;
    else                      wrIdxQ <= nextIdx;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] memQ [DEPTH];
    logic [LEN_W-1:0]  lenQ;
    logic              mine;
    assign mine = (strobe.bufSel == 1'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) memQ[i] <= '0;
      end else if (store && mine) begin
        memQ[wrIdxQ[IDX_W-1:0]] <= wrByte;
      end
    end

    always_ff @(posedge clk) begin
      if (rst || strobe.wipe)            lenQ <= '0;
      else if (strobe.frameEnd && mine)  lenQ <= nextIdx;
    end

    assign rdBank[b]  = memQ[rdAddr];
    assign lenBank[b] = lenQ;
  end

  assign rdData   = rdBank[hostPtr];
  assign frameLen = lenBank[hostPtr];
endmodule

// File: rtl/rx_pair_buf_mgr.sv
module rx_pair_buf_mgr
  import rpb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmdRxEnable,
  input  logic                       cmdRxOff,
  input  logic                       cmdToggle,
  input  logic [3:0]                 statusClr,
  input  logic                       maskWr,
  input  logic [3:0]                 maskData,
  input  logic                       autoReEnable,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output logic [$clog2(DEPTH+1)-1:0] frameLen,
  output logic [3:0]                 hostStatus,
  output logic                       hostPtr,
  output logic                       rxPtr,
  output logic                       rxActive,
  output logic                       overrun,
  output logic                       irq,
  input  logic                       rxByteValid,
  input  logic [DATA_W-1:0]          rxByte,
  input  logic                       rxFrameDone,
  input  logic                       rxCrcErr,
  input  logic                       rxDetect
);
  rpb_strobe_t          strobe;
  logic [NUM_FLAGS-1:0] maskState;

  rpb_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cmdRxEnable(cmdRxEnable), .cmdRxOff(cmdRxOff), .cmdToggle(cmdToggle),
    .statusClr(statusClr), .maskWr(maskWr), .maskData(maskData),
    .autoReEnable(autoReEnable),
    .rxByteValid(rxByteValid), .rxFrameDone(rxFrameDone),
    .rxCrcErr(rxCrcErr), .rxDetect(rxDetect),
    .strobe(strobe), .hostPtr(hostPtr), .rxPtr(rxPtr),
    .rxActive(rxActive), .overrun(overrun), .hostStatus(hostStatus),
    .irq(irq), .maskState(maskState)
  );

  rpb_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .wrByte(rxByte),
    .hostPtr(hostPtr), .rdAddr(rdAddr), .rdData(rdData), .frameLen(frameLen)
  );
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmdRxEnable,
  input logic       cmdRxOff,
  input logic       cmdToggle,
  input logic       autoReEnable,
  input logic       rxFrameDone,
  input logic       hostPtr,
  input logic       rxPtr,
  input logic       rxActive,
  input logic       overrun,
  input logic       irq,
  input logic [3:0] hostStatus,
  input logic [3:0] maskState
);
  logic pastRst;
  always_ff @(posedge clk) pastRst <= rst;

  always @(negedge clk) begin
    if (pastRst)
      AST_RESET_STATE: assert (hostPtr == 1'b0 && rxPtr == 1'b0 && !overrun && !rxActive
                               && !irq && hostStatus == 4'd0 && maskState == 4'hF); // R1
  end

  AST_RXPTR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rxPtr) |-> $past(rxFrameDone || cmdToggle || cmdRxOff)); // R3

  AST_HOST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    cmdToggle && !overrun |=> hostPtr != $past(hostPtr)); // R4

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(rxActive) |-> $past(cmdRxEnable && hostPtr == rxPtr && !overrun)); // R5

  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
    rxFrameDone && rxActive && !autoReEnable && !cmdRxEnable |=> !rxActive); // R6

  AST_OVR_QUIET: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !rxActive); // R7

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
    overrun && !cmdRxOff |=> overrun && $stable(hostPtr)); // R7

  AST_OFF_RECOVER: assert property (@(posedge clk) disable iff (rst)
    overrun && cmdRxOff |=> !overrun && !rxPtr && !hostPtr && hostStatus == 4'd0); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    maskState == 4'hF |-> !irq); // R9
endmodule

bind rx_pair_buf_mgr rpb_checker u_chk (
  .clk(clk), .rst(rst), .cmdRxEnable(cmdRxEnable), .cmdRxOff(cmdRxOff),
  .cmdToggle(cmdToggle), .autoReEnable(autoReEnable), .rxFrameDone(rxFrameDone),
  .hostPtr(hostPtr), .rxPtr(rxPtr), .rxActive(rxActive), .overrun(overrun),
  .irq(irq), .hostStatus(hostStatus), .maskState(maskState)
);

// File: tb/rx_pair_buf_mgr_tb.sv
`timescale 1ns/1ps
module rx_pair_buf_mgr_tb;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LEN_W  = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdRxEnable = 0, cmdRxOff = 0, cmdToggle = 0, maskWr = 0, autoReEnable = 0;
  logic [3:0] statusClr = '0, maskData = '0;
  logic [IDX_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic [LEN_W-1:0] frameLen;
  logic [3:0] hostStatus;
  logic hostPtr, rxPtr, rxActive, overrun, irq;
  logic rxByteValid = 0, rxFrameDone = 0, rxCrcErr = 0, rxDetect = 0;
  logic [DATA_W-1:0] rxByte = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_pair_buf_mgr #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doEnable();
    cmdRxEnable = 1; tick(); cmdRxEnable = 0;
  endtask
  task automatic doOff();
    cmdRxOff = 1; tick(); cmdRxOff = 0;
  endtask
  task automatic doToggle();
    cmdToggle = 1; tick(); cmdToggle = 0;
  endtask
  task automatic setMask(logic [3:0] m);
    maskData = m; maskWr = 1; tick(); maskWr = 0;
  endtask
  task automatic clearFlags(logic [3:0] c);
    statusClr = c; tick(); statusClr = '0;
  endtask
  task automatic sendFrame(int n, logic [7:0] base, logic err);
    for (int i = 0; i < n; i++) begin
      rxByteValid = 1; rxByte = base + 8'(i); tick();
    end
    rxByteValid = 0;
    rxFrameDone = 1; rxCrcErr = err; tick();
    rxFrameDone = 0; rxCrcErr = 0;
  endtask
  task automatic readAt(int a, output int d);
    rdAddr = IDX_W'(a); #1; d = int'(rdData);
  endtask

  task automatic testReset();
    check("R1 hostPtr", int'(hostPtr), 0);
    check("R1 rxPtr", int'(rxPtr), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 rxActive", int'(rxActive), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 status", int'(hostStatus), 0);
  endtask

  task automatic testBasicFrame();
    int d;
    autoReEnable = 0;
    doEnable();
    check("R5 enable accepted", int'(rxActive), 1);
    sendFrame(3, 8'hA1, 0);
    check("R6 stop without auto", int'(rxActive), 0);
    check("R3 rxPtr advanced", int'(rxPtr), 1);
    check("R2 status good+ready", int'(hostStatus), 4'b0101);
    check("R2 length", int'(frameLen), 3);
    readAt(1, d);
    check("R2 byte 1", d, 8'hA2);
    check("R9 irq masked", int'(irq), 0);
    setMask(4'b1011);
    check("R9 irq unmasked ready", int'(irq), 1);
    clearFlags(4'b0100);
    check("R10 clear ignored when unmasked", int'(hostStatus), 4'b0101);
    setMask(4'hF);
    clearFlags(4'b0100);
    check("R10 clear under mask", int'(hostStatus), 4'b0001);
    check("R9 irq after mask", int'(irq), 0);
    doToggle();
    check("R4 hostPtr flipped", int'(hostPtr), 1);
    check("R4 new host buffer empty", int'(hostStatus), 0);
  endtask

  task automatic testEnableGate();
    doToggle();
    check("R4 hostPtr back", int'(hostPtr), 0);
    doEnable();
    check("R5 enable refused on mismatch", int'(rxActive), 0);
    doToggle();
    doEnable();
    check("R5 enable after realign", int'(rxActive), 1);
  endtask

  task automatic testAutoErrTrunc();
    int d;
    autoReEnable = 1;
    rxDetect = 1; tick(); rxDetect = 0;
    sendFrame(6, 8'h10, 1);
    check("R6 still active with auto", int'(rxActive), 1);
    check("R3 rxPtr to empty buf0", int'(rxPtr), 0);
    check("R2 R11 err+ready+detect", int'(hostStatus), 4'b1110);
    check("R12 length saturates", int'(frameLen), DEPTH);
    readAt(3, d);
    check("R12 last stored byte", d, 8'h13);
    sendFrame(2, 8'h20, 0);
    check("R3 rxPtr holds when other full", int'(rxPtr), 0);
    check("R2 host view unchanged", int'(hostStatus), 4'b1110);
    doToggle();
    check("R4 host at buf0", int'(hostPtr), 0);
    check("R2 buf0 status", int'(hostStatus), 4'b0101);
    check("R2 buf0 length", int'(frameLen), 2);
    readAt(0, d);
    check("R2 buf0 byte 0", d, 8'h20);
    check("R3 rxPtr moves on release", int'(rxPtr), 1);
  endtask

  task automatic testOverrun();
    sendFrame(3, 8'h30, 0);
    check("R3 rxPtr holds, both full", int'(rxPtr), 1);
    check("R7 no overrun yet", int'(overrun), 0);
    rxByteValid = 1; rxByte = 8'h55; tick(); rxByteValid = 0;
    check("R7 overrun set", int'(overrun), 1);
    check("R7 receiver stopped", int'(rxActive), 0);
    doEnable();
    check("R7 enable ignored", int'(rxActive), 0);
    doToggle();
    check("R7 toggle ignored", int'(hostPtr), 0);
    doOff();
    check("R8 overrun cleared", int'(overrun), 0);
    check("R8 rxPtr zero", int'(rxPtr), 0);
    check("R8 hostPtr zero", int'(hostPtr), 0);
    check("R8 flags wiped", int'(hostStatus), 0);
    check("R8 length wiped", int'(frameLen), 0);
    doEnable();
    check("R5 enable after recovery", int'(rxActive), 1);
    doOff();
    check("R8 off stops receiver", int'(rxActive), 0);
    check("R8 plain off keeps overrun clear", int'(overrun), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    testReset();
    testBasicFrame();
    testEnableGate();
    testAutoErrTrunc();
    testOverrun();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule